// File: doc/BRIEF.md
# I2C Paged Register Target

This block is a target on a two-wire I2C bus. It answers at one fixed 7-bit address and gives the bus controller access to a bank of 16-bit registers organised as pages. A write transaction sends a page number, then an offset, then zero or more register values as byte pairs. A read transaction returns a window of registers chosen by an earlier selection. The block samples SCL and SDA through synchronisers and pulls SDA low through an open-drain enable. It never drives SCL.

Written bytes are collected in a circular byte buffer. The buffer is interpreted only when the transaction ends, either at a STOP or at the next address match after a repeated START. At that point the block moves the selection or updates the registers one register per system clock. It assumes that SCL is slow enough for this work to finish before the next data byte arrives. A system clock of at least eight times the SCL rate is enough.

Top module: `i2c_page_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x1A, sent as the upper seven bits of the address byte, with bit 0 = 1 for a read. For any other address SDA stays released, and the bytes that follow have no effect.
- R2: In a write, byte 0 is the page and byte 1 is the offset. Each further pair of bytes is one register value, low byte first, stored at consecutive offsets starting at the offset. The register count is (n - 2) / 2, so a trailing odd byte is dropped.
- R3: Every byte of a write addressed to the target is acknowledged by driving SDA low in the ninth clock. SDA changes only while SCL is low.
- R4: A write of 2 or 3 bytes moves the read selection to the given page and offset. A write that carries at least one register pair leaves the read selection unchanged.
- R5: A write of 0 or 1 bytes changes neither the registers nor the selection.
- R6: A read returns the registers from the selected offset to the last register of the page, low byte first.
- R7: A selection with page >= 4 or offset >= 16 is invalid. Such a selection reads as a 4-byte window of 0xFF. After reset the selection is invalid.
- R8: Reading past the end of the window wraps to the window's first byte.
- R9: Each read transaction starts at the first byte of the window. A finished read leaves the selection unchanged, so repeating the read returns the same bytes.
- R10: A register pair aimed at an offset beyond the page end, or at an invalid page, is dropped. Pairs in the same write that fall inside the page are still stored.
- R11: The write buffer holds 68 bytes and wraps. A write of n bytes is handled as n mod 68 bytes, using the most recent byte held at each buffer position.
- R12: A write takes effect at the STOP, or at the address match after a repeated START. A read that follows a repeated START therefore uses the selection made just before it.
- R13: After the controller NACKs a read byte, the target releases SDA and ignores SCL until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bound assertions check four things on every cycle. SDA only changes while SCL is low. A STOP releases SDA and triggers processing of the buffer. Read-pointer and buffer strobes only occur during an SCL low phase. No byte enters the buffer while a register update is still running. Data-level behaviour can only be shown by complete bus transactions in the bench. This covers the page and offset decoding, pairs dropped at the page end, the selection rules for 2- and 3-byte writes, window wrap, the 0xFF pattern for invalid selections, buffer wrap past 68 bytes, and park after a NACK.

// File: rtl/i2c_page_pkg.sv
package i2c_page_pkg;

  // Strobes from the bus controller to the datapath, one-cycle pulses
  typedef struct packed {
    logic push;       // store pushByte into the write buffer
    logic commit;     // interpret and clear the write buffer
    logic rdRestart;  // rewind the read pointer to window start
    logic rdNext;     // advance the read pointer (wraps at window end)
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_PARK
  } busState_t;

endpackage

// File: rtl/i2c_page_ctrl.sv
module i2c_page_ctrl
  import i2c_page_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h1A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclS,
  input  logic        sdaS,
  input  logic [7:0]  rdByte,
  output ctrlStrobe_t ctrlS,
  output logic [7:0]  pushByte,
  output logic        sdaDriveLow
);

  busState_t   state;
  logic        sclPrev, sdaPrev;
  logic [3:0]  bitCnt;
  logic [7:0]  shiftIn;
  logic [7:0]  txShift;
  logic        isRead;
  logic        nackSeen;

  logic sclRise, sclFall, startEv, stopEv;

  always_comb begin
    sclRise = sclS && !sclPrev;
    sclFall = !sclS && sclPrev;
    startEv = sclS && sclPrev && sdaPrev && !sdaS;
    stopEv  = sclS && sclPrev && !sdaPrev && sdaS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sclPrev     <= 1'b1;
      sdaPrev     <= 1'b1;
      bitCnt      <= '0;
      shiftIn     <= '0;
      txShift     <= '0;
      isRead      <= 1'b0;
      nackSeen    <= 1'b0;
      sdaDriveLow <= 1'b0;
      pushByte    <= '0;
      ctrlS       <= '0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      ctrlS   <= '0;
      if (stopEv) begin
        state        <= ST_IDLE;
        sdaDriveLow  <= 1'b0;
        ctrlS.commit <= 1'b1;
      end else if (startEv) begin
        state       <= ST_ADDR;
        bitCnt      <= '0;
        sdaDriveLow <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (sclRise) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftIn[7:1] == TARGET_ADDR) begin
                  sdaDriveLow     <= 1'b1;
                  isRead          <= shiftIn[0];
                  state           <= ST_ADDR_ACK;
                  ctrlS.commit    <= 1'b1;
                  ctrlS.rdRestart <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaDriveLow <= 1'b1;
                pushByte    <= shiftIn;
                ctrlS.push  <= 1'b1;
                state       <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (isRead) begin
                txShift      <= rdByte;
                sdaDriveLow  <= !rdByte[7];
                ctrlS.rdNext <= 1'b1;
                bitCnt       <= '0;
                state        <= ST_RD;
              end else begin
                sdaDriveLow <= 1'b0;
                state       <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (sclFall) begin
              sdaDriveLow <= 1'b0;
              state       <= ST_WR;
            end
          end
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaDriveLow <= 1'b0;
                state       <= ST_RD_ACK;
              end else begin
                txShift     <= {txShift[6:0], 1'b0};
                sdaDriveLow <= !txShift[6];
                bitCnt      <= bitCnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              nackSeen <= sdaS;
            end else if (sclFall) begin
              if (nackSeen) begin
                state <= ST_PARK;
              end else begin
                txShift      <= rdByte;
                sdaDriveLow  <= !rdByte[7];
                ctrlS.rdNext <= 1'b1;
                bitCnt       <= '0;
                state        <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_page_data.sv
module i2c_page_data
  import i2c_page_pkg::*;
#(
  parameter int PAGES     = 4,
  parameter int REGS      = 16,
  parameter int BUF_BYTES = 68
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t ctrlS,
  input  logic [7:0]  pushByte,
  output logic [7:0]  rdByte,
  output logic        applyBusy
);

  localparam int ENTRIES = PAGES * REGS;
  localparam int ENT_W   = $clog2(ENTRIES);
  localparam int PTR_W   = $clog2(BUF_BYTES);
  localparam int IDX_W   = $clog2(2 * REGS + 1);

  logic [7:0]       bufMem  [BUF_BYTES];
  logic [15:0]      regFile [ENTRIES];
  logic [PTR_W-1:0] wrPtr;
  logic [7:0]       rdPage, rdOff;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0]       applyPage, applyOff;
  logic [PTR_W-1:0] applyLeft, applyCnt;

  logic [PTR_W-1:0] commitPairs;
  logic [PTR_W-1:0] loIdx, hiIdx;
  logic [8:0]       tgtOff;
  logic             tgtOk;
  logic [ENT_W-1:0] wrEntry, rdEntry;
  logic             selValid;
  logic [IDX_W-1:0] winLen, idxInc;
  logic [15:0]      rdWord;

  always_comb begin
    applyBusy   = (applyLeft != '0);
    commitPairs = (wrPtr - PTR_W'(2)) >> 1;
    loIdx       = PTR_W'({applyCnt, 1'b0} + 2);
    hiIdx       = loIdx + PTR_W'(1);
    tgtOff      = {1'b0, applyOff} + 9'(applyCnt);
    tgtOk       = (applyPage < 8'(PAGES)) && (tgtOff < 9'(REGS));
    wrEntry     = ENT_W'(int'(applyPage) * REGS + int'(tgtOff));
    selValid    = (rdPage < 8'(PAGES)) && (rdOff < 8'(REGS));
    winLen      = selValid ? IDX_W'(2 * (REGS - int'(rdOff))) : IDX_W'(4);
    idxInc      = rdIdx + IDX_W'(1);
    rdEntry     = ENT_W'(int'(rdPage) * REGS + int'(rdOff) + int'(rdIdx >> 1));
    rdWord      = regFile[rdEntry];
    rdByte      = !selValid ? 8'hFF : (rdIdx[0] ? rdWord[15:8] : rdWord[7:0]);
  end

  // Circular capture buffer, no reset needed on the storage itself
  always_ff @(posedge clk) begin
    if (ctrlS.push) bufMem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      rdPage    <= 8'hFF;
      rdOff     <= 8'hFF;
      applyPage <= '0;
      applyOff  <= '0;
      applyLeft <= '0;
      applyCnt  <= '0;
    end else begin
      if (ctrlS.commit) begin
        wrPtr <= '0;
        if (wrPtr >= PTR_W'(2) && !applyBusy) begin
          if (commitPairs == '0) begin
            rdPage <= bufMem[0];
            rdOff  <= bufMem[1];
          end else begin
            applyPage <= bufMem[0];
            applyOff  <= bufMem[1];
            applyLeft <= commitPairs;
            applyCnt  <= '0;
          end
        end
      end else if (ctrlS.push) begin
        wrPtr <= (wrPtr == PTR_W'(BUF_BYTES - 1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (applyBusy) begin
        applyLeft <= applyLeft - PTR_W'(1);
        applyCnt  <= applyCnt + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) regFile[i] <= '0;
    end else if (applyBusy && tgtOk) begin
      regFile[wrEntry] <= {bufMem[hiIdx], bufMem[loIdx]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdIdx <= '0;
    end else if (ctrlS.rdRestart) begin
      rdIdx <= '0;
    end else if (ctrlS.rdNext) begin
      rdIdx <= (idxInc >= winLen) ? '0 : idxInc;
    end
  end

endmodule

// File: rtl/i2c_page_target.sv
module i2c_page_target
  import i2c_page_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h1A,
  parameter int         PAGES       = 4,
  parameter int         REGS        = 16,
  parameter int         BUF_BYTES   = 68
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);

  logic [1:0]  sclSync, sdaSync;
  logic        sclS, sdaS;
  ctrlStrobe_t ctrlS;
  logic [7:0]  pushByte;
  logic [7:0]  rdByte;
  logic        applyBusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  i2c_page_ctrl #(
    .TARGET_ADDR(TARGET_ADDR)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclS       (sclS),
    .sdaS       (sdaS),
    .rdByte     (rdByte),
    .ctrlS      (ctrlS),
    .pushByte   (pushByte),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_page_data #(
    .PAGES    (PAGES),
    .REGS     (REGS),
    .BUF_BYTES(BUF_BYTES)
  ) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrlS    (ctrlS),
    .pushByte (pushByte),
    .rdByte   (rdByte),
    .applyBusy(applyBusy)
  );

endmodule

// File: rtl/i2c_page_checker.sv
module i2c_page_checker
  import i2c_page_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sclS,
  input logic        sdaS,
  input logic        sdaDriveLow,
  input ctrlStrobe_t ctrlS,
  input logic        applyBusy
);

  logic sclPrevC, sdaPrevC, stopSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrevC <= 1'b1;
      sdaPrevC <= 1'b1;
    end else begin
      sclPrevC <= sclS;
      sdaPrevC <= sdaS;
    end
  end

  assign stopSeen = sclS && sclPrevC && !sdaPrevC && sdaS;

  // R3: the data line is only changed by the target while the clock is low
  a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !sclS);

  // R13: a STOP always leaves SDA released
  a_r13_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> !sdaDriveLow);

  // R12: a STOP always triggers interpretation of the buffer
  a_r12_stop_commit: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> ctrlS.commit);

  // R8: the read pointer only moves during a clock low phase
  a_r8_rdnext_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlS.rdNext |-> !sclS);

  // R9: the read pointer rewinds at the address acknowledge, clock low
  a_r9_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlS.rdRestart |-> !sclS);

  // R11: no byte enters the buffer while register updates are in flight
  a_r11_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlS.push |-> !applyBusy);

endmodule

bind i2c_page_target i2c_page_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclS       (sclS),
  .sdaS       (sdaS),
  .sdaDriveLow(sdaDriveLow),
  .ctrlS      (ctrlS),
  .applyBusy  (applyBusy)
);

// File: tb/i2c_page_target_tb_top.sv
`timescale 1ns/1ps
module i2c_page_target_tb_top;

  localparam int TQ = 32;               // quarter SCL period in ns (4 clocks)
  localparam logic [6:0] TGT = 7'h1A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclIn = 1'b1;
  logic tbSdaLow = 1'b0;
  logic sdaDriveLow;
  wire  sdaLine = !(tbSdaLow || sdaDriveLow);

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [7:0]  txData [80];
  int          txLen;
  logic [15:0] expRegs [4][16];
  int          selPage = 255;
  int          selOff = 255;

  always #4 clk = ~clk;

  i2c_page_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclIn      (sclIn),
    .sdaIn      (sdaLine),
    .sdaDriveLow(sdaDriveLow)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int k);
    int win;
    int kk;
    logic [15:0] w;
    if (selPage < 4 && selOff < 16) begin
      win = 2 * (16 - selOff);
      kk = k % win;
      w = expRegs[selPage][selOff + kk / 2];
      return (kk % 2 == 1) ? w[15:8] : w[7:0];
    end
    return 8'hFF;
  endfunction

  task automatic modelWrite();
    logic [7:0] mb [68];
    int cnt;
    int pairs;
    for (int j = 0; j < 68; j++) mb[j] = 8'h00;
    for (int j = 0; j < txLen; j++) mb[j % 68] = txData[j];
    cnt = txLen % 68;
    if (cnt < 2) return;
    pairs = (cnt - 2) / 2;
    if (pairs == 0) begin
      selPage = int'(mb[0]);
      selOff  = int'(mb[1]);
    end else begin
      for (int i = 0; i < pairs; i++) begin
        int o;
        o = int'(mb[1]) + i;
        if (mb[0] < 4 && o < 16) expRegs[mb[0]][o] = {mb[3 + 2 * i], mb[2 + 2 * i]};
      end
    end
  endtask

  task automatic busStart();
    tbSdaLow = 1'b0; #(2 * TQ);
    sclIn = 1'b1;    #(2 * TQ);
    tbSdaLow = 1'b1; #(2 * TQ);
    sclIn = 1'b0;
  endtask

  task automatic busStop();
    tbSdaLow = 1'b1; #(2 * TQ);
    sclIn = 1'b1;    #(2 * TQ);
    tbSdaLow = 1'b0; #(8 * TQ);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ackLow);
    for (int i = 7; i >= 0; i--) begin
      tbSdaLow = !b[i]; #(2 * TQ);
      sclIn = 1'b1;     #(2 * TQ);
      sclIn = 1'b0;
    end
    tbSdaLow = 1'b0; #(2 * TQ);
    sclIn = 1'b1;    #(TQ);
    ackLow = !sdaLine;
    #(TQ);
    sclIn = 1'b0;
  endtask

  task automatic recvByte(input bit lastByte, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tbSdaLow = 1'b0; #(2 * TQ);
      sclIn = 1'b1;    #(TQ);
      b[i] = sdaLine;
      #(TQ);
      sclIn = 1'b0;
    end
    tbSdaLow = !lastByte; #(2 * TQ);
    sclIn = 1'b1;         #(2 * TQ);
    sclIn = 1'b0;
    tbSdaLow = 1'b0;
  endtask

  task automatic doWrite(input logic [6:0] addr, input bit withStop);
    bit a;
    bit hit;
    hit = (addr == TGT);
    busStart();
    sendByte({addr, 1'b0}, a);
    chkEq("R1 address ack", int'(a), int'(hit));
    for (int j = 0; j < txLen; j++) begin
      sendByte(txData[j], a);
      chkEq(hit ? "R3 data ack" : "R1 foreign data ignored", int'(a), int'(hit));
    end
    if (hit) modelWrite();
    if (withStop) busStop();
  endtask

  task automatic doRead(input int n, input string req, input bit park);
    bit a;
    logic [7:0] b;
    busStart();
    sendByte({TGT, 1'b1}, a);
    chkEq("R1 read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k == n - 1, b);
      chkEq(req, int'(b), int'(expByte(k)));
    end
    if (park) begin
      for (int c = 0; c < 9; c++) begin
        #(2 * TQ); sclIn = 1'b1; #(TQ);
        chkEq("R13 released after NACK", int'(sdaLine), 1);
        #(TQ); sclIn = 1'b0;
      end
    end
    busStop();
  endtask

  task automatic selectWin(input int p, input int o, input bit withStop);
    txData[0] = 8'(p); txData[1] = 8'(o); txLen = 2;
    doWrite(TGT, withStop);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int p = 0; p < 4; p++) for (int r = 0; r < 16; r++) expRegs[p][r] = 16'h0000;
    #80 rst_n = 1'b1;
    #80;
    chkEq("R7 reset: SDA released", int'(sdaDriveLow), 0);

    // R7/R8: selection invalid after reset, 0xFF window of 4 wraps
    doRead(6, "R7 reset read 0xFF", 1'b0);

    // R1: a foreign address writing data has no effect
    txData[0] = 8'h00; txData[1] = 8'h00; txData[2] = 8'h55; txData[3] = 8'hAA; txLen = 4;
    doWrite(7'h1B, 1'b1);
    selectWin(0, 0, 1'b1);
    doRead(4, "R1 foreign write no effect", 1'b0);

    // R2/R10: write 3 registers at page 1 offset 14, the third falls off
    txData[0] = 8'd1; txData[1] = 8'd14;
    txData[2] = 8'h11; txData[3] = 8'h22; txData[4] = 8'h33; txData[5] = 8'h44;
    txData[6] = 8'h55; txData[7] = 8'h66; txData[8] = 8'h77; txLen = 9;
    doWrite(TGT, 1'b1);
    selectWin(2, 0, 1'b1);
    doRead(2, "R10 next page untouched", 1'b0);
    selectWin(1, 14, 1'b1);
    doRead(10, "R8 window wrap page1 off14", 1'b0);

    // R9: repeated read returns the same bytes
    doRead(4, "R9 repeat read", 1'b0);

    // R4: data write leaves selection unchanged
    txData[0] = 8'd2; txData[1] = 8'd0; txData[2] = 8'hA5; txData[3] = 8'h5A; txLen = 4;
    doWrite(TGT, 1'b1);
    doRead(4, "R4 data write keeps selection", 1'b0);

    // R5: 0- and 1-byte writes are ignored
    txLen = 0; doWrite(TGT, 1'b1);
    txData[0] = 8'd2; txLen = 1; doWrite(TGT, 1'b1);
    doRead(4, "R5 short write ignored", 1'b0);

    // R4: 3-byte write selects page 2 offset 0 (odd byte dropped)
    txData[0] = 8'd2; txData[1] = 8'd0; txData[2] = 8'hEE; txLen = 3;
    doWrite(TGT, 1'b1);
    doRead(3, "R4 three-byte select", 1'b0);

    // R7: invalid offset and invalid page
    selectWin(0, 16, 1'b1);
    doRead(6, "R7 invalid offset 0xFF", 1'b0);
    selectWin(4, 0, 1'b1);
    doRead(5, "R7 invalid page 0xFF", 1'b0);

    // R12: select then repeated START read
    selectWin(1, 15, 1'b0);
    doRead(3, "R12 repeated start read", 1'b0);

    // R13: NACK then park
    doRead(2, "R13 read before park", 1'b1);

    // R11: 70-byte write wraps, leaving a 2-byte selection of page 3 offset 2
    for (int j = 0; j < 70; j++) txData[j] = 8'(8'h40 + j);
    txData[68] = 8'd3; txData[69] = 8'd2; txLen = 70;
    doWrite(TGT, 1'b1);
    doRead(4, "R11 buffer wrap selection", 1'b0);

    // R2/R6: random writes and reads against the model
    for (int it = 0; it < 20; it++) begin
      int p, o, nr;
      p  = int'($urandom_range(0, 4));
      o  = int'($urandom_range(0, 17));
      nr = int'($urandom_range(0, 5));
      txData[0] = 8'(p); txData[1] = 8'(o);
      for (int j = 0; j < 2 * nr; j++) txData[2 + j] = 8'($urandom);
      txLen = 2 + 2 * nr;
      doWrite(TGT, 1'b1);
      selectWin(int'($urandom_range(0, 4)), int'($urandom_range(0, 17)), 1'b1);
      doRead(int'($urandom_range(1, 9)), "R6 random read", 1'b0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule